// File: doc/BRIEF.md
# GPIO Port with Alternate-Function Multiplexer

This block is a 16-pin general-purpose I/O port. Software sets it up through a small word-addressed register interface. For each pin it chooses whether the pad is driven from the port's own output data register or from one of sixteen peripheral sources. It then applies push-pull or open-drain shaping, pull selection and analog gating to the chosen source. The result goes to the pad as a drive value, an output enable, two pull enables, a speed code and an analog enable.

Pad input levels pass through a two-flop synchroniser and can be read back as a single input word. A pin placed in analog mode has no digital effect on the pad and always reads as 0. Peripherals attach through two flat buses of sixteen lanes per pin, one for drive values and one for output enables. The per-pin alternate-function code picks one lane from each bus.

Top module: `gpio_af_port`

## Requirements
- R1: After reset, every configuration register, the output data register and the input word read 0. All pins are in input mode, and pad_oe, pad_pull_up, pad_pull_dn, pad_ana and pad_speed are all 0.
- R2: Word addresses are 0 mode (2 bits per pin), 1 output type (1 bit), 2 speed (2 bits), 3 pull (2 bits), 4 function select for pins 0-7 (4 bits), 5 function select for pins 8-15 (4 bits), 6 output data (1 bit) and 7 input data (1 bit). Pin n's field starts at bit n times the field width within its register. Written values read back on reg_rdata in the cycle after the write, and bits above the last field read 0.
- R3: Mode code 01 (output) with push-pull drives pad_oe high and pad_out equal to the pin's output data bit.
- R4: Mode code 10 (alternate function) takes drive and enable only from lane pin*16+code of alt_drive and alt_oe, where code is the pin's 4-bit select (0000 is function 0, 1111 is function 15). All other lanes have no effect on that pin.
- R5: Output type 1 (open-drain) forces pad_out to 0 and asserts pad_oe only while the enabled source drives 0. A source value of 1 releases the pin.
- R6: Pull code 01 asserts pad_pull_up, code 10 asserts pad_pull_dn, and codes 00 and 11 assert neither.
- R7: Mode code 11 (analog) asserts pad_ana, forces pad_oe and both pull enables to 0, and makes the pin read as 0 in the input word.
- R8: Each pin's 2-bit speed field appears unchanged on pad_speed[2n+1:2n].
- R9: A change on pin_in shows in the input word after exactly two rising clock edges. Mode 00 (input) keeps pad_oe low.
- R10: Writes to address 7 (input data) are ignored and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pin_in | input | 16 | Raw pad input levels |
| alt_drive | input | 256 | Peripheral drive values, lane pin*16+function |
| alt_oe | input | 256 | Peripheral output enables, lane pin*16+function |
| pad_out | output | 16 | Pad drive value |
| pad_oe | output | 16 | Pad output enable |
| pad_pull_up | output | 16 | Pull-up enable |
| pad_pull_dn | output | 16 | Pull-down enable |
| pad_speed | output | 32 | Speed code, 2 bits per pin |
| pad_ana | output | 16 | Analog enable |

## Verification
The hardest case to reach from the ports is a pin that is in alternate-function mode with a non-zero select code, or one that sits in the upper select register. There, an error in lane selection only shows if the selected lane and its neighbours carry different values. The stimulus first sets only the selected lane and then sets every lane except it, so a lane that is wrong or shifted changes pad_out. A second case is open-drain combined with analog gating: the stimulus mixes several modes across pins in one configuration, and the whole pad word is compared at once.

// File: rtl/gpio_af_pkg.sv
package gpio_af_pkg;

   localparam int ADDR_W    = 3;
   localparam int ALT_SEL_W = 4;
   localparam int MODE_W    = 2;
   localparam int SPEED_W   = 2;
   localparam int PULL_W    = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_IN  = 2'b00,
      MODE_OUT = 2'b01,
      MODE_ALT = 2'b10,
      MODE_ANA = 2'b11
   } pin_mode_e;

   localparam logic [PULL_W-1:0] PULL_UP_C   = 2'b01;
   localparam logic [PULL_W-1:0] PULL_DOWN_C = 2'b10;

   localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
   localparam logic [ADDR_W-1:0] A_OTYPE  = 3'd1;
   localparam logic [ADDR_W-1:0] A_SPEED  = 3'd2;
   localparam logic [ADDR_W-1:0] A_PULL   = 3'd3;
   localparam logic [ADDR_W-1:0] A_ALT_LO = 3'd4;
   localparam logic [ADDR_W-1:0] A_ALT_HI = 3'd5;
   localparam logic [ADDR_W-1:0] A_ODATA  = 3'd6;
   localparam logic [ADDR_W-1:0] A_IDATA  = 3'd7;

   typedef struct packed {
      pin_mode_e            mode;
      logic                 open_drain;
      logic [SPEED_W-1:0]   speed;
      logic [PULL_W-1:0]    pull;
      logic [ALT_SEL_W-1:0] alt_sel;
      logic                 odata;
   } pin_cfg_t;

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_af_pkg::*;
#(
   parameter int NUM_PINS = 16,
   parameter int DATA_W   = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [NUM_PINS-1:0]           idata,
   output pin_cfg_t [NUM_PINS-1:0]       cfg,
   output logic [DATA_W-1:0]             rdata
);

   localparam int ALT_PER_REG = DATA_W / ALT_SEL_W;

   pin_cfg_t [NUM_PINS-1:0] cfg_q;

   initial begin : param_chk
      assert (MODE_W * NUM_PINS <= DATA_W)
         else $fatal(1, "mode fields do not fit one word");
      assert (NUM_PINS <= 2 * ALT_PER_REG)
         else $fatal(1, "select fields need more than two words");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            case (addr)
               A_MODE:   cfg_q[p].mode       <= pin_mode_e'(wdata[MODE_W*p +: MODE_W]);
               A_OTYPE:  cfg_q[p].open_drain <= wdata[p];
               A_SPEED:  cfg_q[p].speed      <= wdata[SPEED_W*p +: SPEED_W];
               A_PULL:   cfg_q[p].pull       <= wdata[PULL_W*p +: PULL_W];
               A_ALT_LO: if (p < ALT_PER_REG)
                            cfg_q[p].alt_sel <= wdata[ALT_SEL_W*(p % ALT_PER_REG) +: ALT_SEL_W];
               A_ALT_HI: if (p >= ALT_PER_REG)
                            cfg_q[p].alt_sel <= wdata[ALT_SEL_W*(p % ALT_PER_REG) +: ALT_SEL_W];
               A_ODATA:  cfg_q[p].odata      <= wdata[p];
               default:  ;
            endcase
         end
      end
   end

   assign cfg = cfg_q;

   logic [DATA_W-1:0] w_mode, w_otype, w_speed, w_pull;
   logic [DATA_W-1:0] w_alo, w_ahi, w_odata, w_idata;

   always_comb begin
      w_mode  = '0;
      w_otype = '0;
      w_speed = '0;
      w_pull  = '0;
      w_alo   = '0;
      w_ahi   = '0;
      w_odata = '0;
      w_idata = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         w_mode[MODE_W*p +: MODE_W]   = cfg_q[p].mode;
         w_otype[p]                   = cfg_q[p].open_drain;
         w_speed[SPEED_W*p +: SPEED_W] = cfg_q[p].speed;
         w_pull[PULL_W*p +: PULL_W]   = cfg_q[p].pull;
         if (p < ALT_PER_REG)
            w_alo[ALT_SEL_W*(p % ALT_PER_REG) +: ALT_SEL_W] = cfg_q[p].alt_sel;
         else
            w_ahi[ALT_SEL_W*(p % ALT_PER_REG) +: ALT_SEL_W] = cfg_q[p].alt_sel;
         w_odata[p] = cfg_q[p].odata;
         w_idata[p] = idata[p];
      end
   end

   always_comb begin
      case (addr)
         A_MODE:   rdata = w_mode;
         A_OTYPE:  rdata = w_otype;
         A_SPEED:  rdata = w_speed;
         A_PULL:   rdata = w_pull;
         A_ALT_LO: rdata = w_alo;
         A_ALT_HI: rdata = w_ahi;
         A_ODATA:  rdata = w_odata;
         default:  rdata = w_idata;
      endcase
   end

   // R10: a write aimed at the input word leaves every stored field alone
   assert_idata_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_IDATA) |=> $stable(cfg_q));

   // R2: an output data write lands in the per-pin bits
   assert_odata_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_ODATA) |=> (w_odata[NUM_PINS-1:0] == $past(wdata[NUM_PINS-1:0])));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin : param_chk
      assert (STAGES >= 2) else $fatal(1, "synchroniser needs two stages");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
   import gpio_af_pkg::*;
#(
   parameter int NUM_ALT = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  pin_cfg_t           cfg,
   input  logic [NUM_ALT-1:0] alt_drv,
   input  logic [NUM_ALT-1:0] alt_en,
   input  logic               sync_in,
   output logic               pad_out,
   output logic               pad_oe,
   output logic               pad_pu,
   output logic               pad_pd,
   output logic [SPEED_W-1:0] pad_speed,
   output logic               pad_ana,
   output logic               idata
);

   initial begin : param_chk
      assert (NUM_ALT >= 1 && NUM_ALT <= (1 << ALT_SEL_W))
         else $fatal(1, "function count exceeds select code range");
   end

   logic alt_d, alt_e;

   generate
      if (NUM_ALT > 1) begin : g_alt_mux
         localparam int IDX_W = $clog2(NUM_ALT);
         logic             in_range;
         logic [IDX_W-1:0] idx;
         assign in_range = {1'b0, cfg.alt_sel} < (ALT_SEL_W+1)'(NUM_ALT);
         assign idx      = cfg.alt_sel[IDX_W-1:0];
         assign alt_d    = in_range & alt_drv[idx];
         assign alt_e    = in_range & alt_en[idx];
      end else begin : g_alt_single
         assign alt_d = (cfg.alt_sel == '0) & alt_drv[0];
         assign alt_e = (cfg.alt_sel == '0) & alt_en[0];
      end
   endgenerate

   logic src_d, src_e;

   always_comb begin
      src_d = cfg.odata;
      src_e = 1'b0;
      case (cfg.mode)
         MODE_OUT: src_e = 1'b1;
         MODE_ALT: begin
            src_d = alt_d;
            src_e = alt_e;
         end
         default: ;
      endcase
   end

   assign pad_ana = (cfg.mode == MODE_ANA);

   always_comb begin
      if (pad_ana) begin
         pad_out = 1'b0;
         pad_oe  = 1'b0;
      end else if (cfg.open_drain) begin
         pad_out = 1'b0;
         pad_oe  = src_e & ~src_d;
      end else begin
         pad_out = src_d;
         pad_oe  = src_e;
      end
   end

   assign pad_pu    = ~pad_ana & (cfg.pull == PULL_UP_C);
   assign pad_pd    = ~pad_ana & (cfg.pull == PULL_DOWN_C);
   assign pad_speed = cfg.speed;
   assign idata     = ~pad_ana & sync_in;

   // R3: push-pull output mode drives the data bit
   assert_pp_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == MODE_OUT && !cfg.open_drain) |-> (pad_oe && pad_out == cfg.odata));

   // R5: open-drain releases on a high source
   assert_od_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == MODE_OUT && cfg.open_drain && cfg.odata) |-> (!pad_oe && !pad_out));

   // R6: reserved pull code enables nothing
   assert_pull_resv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.pull == 2'b11) |-> (!pad_pu && !pad_pd));

   // R7: analog pins are digitally silent
   assert_ana_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == MODE_ANA) |-> (!pad_oe && !pad_pu && !pad_pd && !idata));

   // R9: input mode never enables the driver
   assert_in_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == MODE_IN) |-> !pad_oe);

endmodule

// File: rtl/gpio_af_port.sv
module gpio_af_port
   import gpio_af_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int NUM_ALT     = 16,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int ALT_BUS_W  = NUM_PINS * NUM_ALT,
   localparam int SPD_BUS_W  = NUM_PINS * SPEED_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [NUM_PINS-1:0]  pin_in,
   input  logic [ALT_BUS_W-1:0] alt_drive,
   input  logic [ALT_BUS_W-1:0] alt_oe,
   output logic [NUM_PINS-1:0]  pad_out,
   output logic [NUM_PINS-1:0]  pad_oe,
   output logic [NUM_PINS-1:0]  pad_pull_up,
   output logic [NUM_PINS-1:0]  pad_pull_dn,
   output logic [SPD_BUS_W-1:0] pad_speed,
   output logic [NUM_PINS-1:0]  pad_ana
);

   initial begin : param_chk
      assert (NUM_PINS >= 1 && NUM_PINS <= 16)
         else $fatal(1, "pin count out of range");
      assert (DATA_W == 32)
         else $fatal(1, "register word must be 32 bits");
   end

   pin_cfg_t [NUM_PINS-1:0] cfg;
   logic [NUM_PINS-1:0]     sync_q;
   logic [NUM_PINS-1:0]     idata;

   gpio_cfg_regs #(
      .NUM_PINS (NUM_PINS),
      .DATA_W   (DATA_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .idata (idata),
      .cfg   (cfg),
      .rdata (reg_rdata)
   );

   gpio_in_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_q)
   );

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         gpio_pin_ctrl #(
            .NUM_ALT (NUM_ALT)
         ) u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg       (cfg[p]),
            .alt_drv   (alt_drive[p*NUM_ALT +: NUM_ALT]),
            .alt_en    (alt_oe[p*NUM_ALT +: NUM_ALT]),
            .sync_in   (sync_q[p]),
            .pad_out   (pad_out[p]),
            .pad_oe    (pad_oe[p]),
            .pad_pu    (pad_pull_up[p]),
            .pad_pd    (pad_pull_dn[p]),
            .pad_speed (pad_speed[p*SPEED_W +: SPEED_W]),
            .pad_ana   (pad_ana[p]),
            .idata     (idata[p])
         );
      end
   endgenerate

   // R6: a pin never pulls both ways
   assert_pull_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pull_up & pad_pull_dn) == '0);

endmodule

// File: tb/sim_gpio_af_port.sv
`timescale 1ns/1ps
module sim_gpio_af_port;

   localparam int SEL_RD = 0, SEL_OUT = 1, SEL_OE = 2, SEL_PU = 3,
                  SEL_PD = 4, SEL_ANA = 5, SEL_SPD = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [15:0]  pin_in = '0;
   logic [255:0] alt_drive = '0;
   logic [255:0] alt_oe = '0;
   logic [15:0]  pad_out, pad_oe, pad_pull_up, pad_pull_dn, pad_ana;
   logic [31:0]  pad_speed;

   always #2.5 clk = ~clk;

   gpio_af_port u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .alt_drive(alt_drive), .alt_oe(alt_oe), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
      .pad_speed(pad_speed), .pad_ana(pad_ana)
   );

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];
   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 1'b0;

   // monitor: pops expectations and compares against the observed port
   initial begin
      item_t       it;
      logic [31:0] obs;
      forever begin
         wait (sb_q.size() != 0);
         it = sb_q.pop_front();
         case (it.sel)
            SEL_RD:  obs = reg_rdata;
            SEL_OUT: obs = {16'h0, pad_out};
            SEL_OE:  obs = {16'h0, pad_oe};
            SEL_PU:  obs = {16'h0, pad_pull_up};
            SEL_PD:  obs = {16'h0, pad_pull_dn};
            SEL_ANA: obs = {16'h0, pad_ana};
            default: obs = pad_speed;
         endcase
         n_tests++;
         if (obs !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.tag, obs, it.exp);
         end
      end
   end

   task automatic expect_val(input int sel, input logic [31:0] e, input string tag);
      item_t it;
      it.sel = sel; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
      reg_addr = a;
      #1;
      expect_val(SEL_RD, e, tag);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      for (int a = 0; a < 8; a++) rd_chk(a[2:0], 32'h0, "R1 reset register read");
      expect_val(SEL_OE,  32'h0, "R1 reset pad_oe");
      expect_val(SEL_PU,  32'h0, "R1 reset pull-up");
      expect_val(SEL_PD,  32'h0, "R1 reset pull-down");
      expect_val(SEL_ANA, 32'h0, "R1 reset analog");
      expect_val(SEL_SPD, 32'h0, "R1 reset speed");

      // R9 two-edge synchroniser latency
      pin_in = 16'hA5C3;
      @(posedge clk); #1;
      rd_chk(3'd7, 32'h0, "R9 input after one edge");
      @(posedge clk); #1;
      rd_chk(3'd7, 32'h0000A5C3, "R9 input after two edges");
      expect_val(SEL_OE, 32'h0, "R9 input mode keeps oe low");

      // R2/R3/R7 mixed modes: pins 0,1 out, 3 and 12 alt, 7 analog
      wr(3'd0, 32'h0200C085);
      rd_chk(3'd0, 32'h0200C085, "R2 mode readback");
      wr(3'd6, 32'hFFFF0001);
      rd_chk(3'd6, 32'h00000001, "R2 output data upper bits read 0");
      expect_val(SEL_OUT, 32'h0001, "R3 push-pull drive");
      expect_val(SEL_OE,  32'h0003, "R3 push-pull enable");
      expect_val(SEL_ANA, 32'h0080, "R7 analog enable");
      rd_chk(3'd7, 32'h0000A543, "R7 analog pin reads 0");

      // R4 lane selection, low select register, pin 3 code 5
      wr(3'd4, 32'h00005000);
      rd_chk(3'd4, 32'h00005000, "R2 select low readback");
      alt_drive = '0; alt_oe = '0;
      alt_drive[53] = 1'b1; alt_oe[53] = 1'b1;
      #1;
      expect_val(SEL_OUT, 32'h0009, "R4 selected lane drives");
      expect_val(SEL_OE,  32'h000B, "R4 selected lane enables");
      alt_drive = ~256'h0; alt_drive[53] = 1'b0; alt_oe = ~256'h0;
      #1;
      expect_val(SEL_OUT, 32'h1001, "R4 neighbour lanes ignored");
      expect_val(SEL_OE,  32'h100B, "R4 neighbour lanes enable");

      // R4 high select register, pin 12 code 14
      wr(3'd5, 32'h000E0000);
      rd_chk(3'd5, 32'h000E0000, "R2 select high readback");
      alt_drive = '0; alt_drive[206] = 1'b1;
      #1;
      expect_val(SEL_OUT, 32'h1001, "R4 high pin lane 14");
      alt_drive = '0; alt_drive[192] = 1'b1;
      #1;
      expect_val(SEL_OUT, 32'h0001, "R4 high pin lane 0 ignored");

      // R5 open-drain on pins 0 and 1
      wr(3'd1, 32'h00000003);
      rd_chk(3'd1, 32'h00000003, "R2 output type readback");
      alt_drive = '0; alt_drive[206] = 1'b1;
      #1;
      expect_val(SEL_OE,  32'h100A, "R5 open-drain enable");
      expect_val(SEL_OUT, 32'h1000, "R5 open-drain drive");

      // R6/R7 pulls
      wr(3'd3, 32'h00004E10);
      rd_chk(3'd3, 32'h00004E10, "R2 pull readback");
      expect_val(SEL_PU, 32'h0004, "R6 pull-up codes, R7 analog suppress");
      expect_val(SEL_PD, 32'h0010, "R6 pull-down and reserved code");

      // R8 speed
      wr(3'd2, 32'hDEADBEEF);
      expect_val(SEL_SPD, 32'hDEADBEEF, "R8 speed passthrough");
      rd_chk(3'd2, 32'hDEADBEEF, "R2 speed readback");

      // R10 input word is read-only
      wr(3'd7, 32'hFFFFFFFF);
      rd_chk(3'd7, 32'h0000A543, "R10 input unchanged");
      rd_chk(3'd0, 32'h0200C085, "R10 mode unchanged");
      rd_chk(3'd1, 32'h00000003, "R10 output type unchanged");
      rd_chk(3'd6, 32'h00000001, "R10 output data unchanged");
      rd_chk(3'd4, 32'h00005000, "R10 select low unchanged");

      // R7/R6 pin 7 back to input restores pull and input
      wr(3'd0, 32'h02000085);
      expect_val(SEL_PU,  32'h0084, "R6 pull-up after leaving analog");
      expect_val(SEL_ANA, 32'h0000, "R7 analog cleared");
      rd_chk(3'd7, 32'h0000A5C3, "R7 digital input returns");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule